// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Multiplier

This block forms the Montgomery product X·Y·2^-n mod N for n-bit operands. It is the building block of a modular exponentiator: an operand is moved into and out of the Montgomery domain, and each squaring or multiplication in the chain is one pass through this unit. The width n is a parameter, 9 by default. The modulus N must be odd. Both operands must be less than N.

The datapath is a bit-level array with one row per bit of X. Each row adds x_k·Y and q·N to a running sum and then halves it. That running sum is carried between rows as a pair of vectors, a sum vector and a carry vector, so no carry has to propagate inside the array. The cell at the least significant position of every row holds an extra XOR gate, which derives the quotient bit q from the low bits of the running sum and from x_k·y0. After the array, a register stage captures the sum/carry pair. A parallel-prefix carry-lookahead adder then resolves the pair to binary. A final conditional subtraction of N brings the value into [0, N). The result is registered.

A request is presented with `inValid` together with the operands. The answer appears two clock edges later with `outValid`. A new request can be accepted on every cycle.

Top module: `montMulTop`

## Requirements
- R1: When `inValid` is high with X < N, Y < N and N odd, the reported result equals the integer Z in [0, N) for which Z·2^n ≡ X·Y (mod N).
- R2: Whenever `outValid` is high, `result` is strictly less than the modulus that was supplied with that request.
- R3: `outValid` is high on the cycle exactly two rising edges after the edge that sampled `inValid` high, and it is low on every other cycle.
- R4: While reset (`rstN` low) is held, `outValid` is 0 and `result` is 0.
- R5: On cycles when `outValid` is low, `result` keeps its previous value. Operand values presented with `inValid` low have no effect on it.
- R6: Requests issued on consecutive cycles are each answered on consecutive cycles, in issue order, with no interference between them.
- R7: If either operand is zero, the result is zero.
- R8: The extreme moduli are handled: N = 1 yields 0, and N = 2^n − 1 with both operands at N − 1 yields the correct product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on this cycle are a request |
| opX | input | OPW | Multiplier operand X, below N |
| opY | input | OPW | Multiplicand operand Y, below N |
| modN | input | OPW | Odd modulus N |
| outValid | output | 1 | `result` holds a new answer on this cycle |
| result | output | OPW | Montgomery product X·Y·2^-n mod N |

## Verification
Every answer is due two rising edges after the edge that accepted its request: one edge for the carry-save register and one for the result register. The bench drives each request on a falling edge and pushes the expected outcome, valid or idle, into a queue on that same falling edge. At each later falling edge it pops the entry pushed two falling edges earlier and compares it with the ports, so every output is sampled exactly at its due cycle. The same queue makes an answer that is one cycle early or late show up as a mismatch in `outValid`. On idle cycles the bench expects `result` to keep the last expected value, regardless of the operand values being driven.

// File: rtl/montPkg.sv
package montPkg;

  // Strobes issued by the sequencing logic to the datapath.
  typedef struct packed {
    logic csLoad;   // capture carry-save output of the array
    logic resLoad;  // capture resolved and reduced result
  } montStrobes_t;

  // Guard bits above the operand width for the running sum.
  localparam int GUARD_BITS = 2;

endpackage

// File: rtl/montCell.sv
// Basic array cell: two stacked full adders.
// Layer one adds x_k*y_j into the sum/carry pair,
// layer two adds q*n_j together with the layer-one carry from the bit below.
module montCell (
  input  logic sIn,
  input  logic cIn,
  input  logic xyBit,
  input  logic qBit,
  input  logic nBit,
  input  logic c1Lower,
  output logic c1Out,
  output logic s2Out,
  output logic c2Out
);
  logic s1;
  logic qn;

  assign s1    = sIn ^ cIn ^ xyBit;
  assign c1Out = (sIn & cIn) | (sIn & xyBit) | (cIn & xyBit);
  assign qn    = qBit & nBit;
  assign s2Out = s1 ^ c1Lower ^ qn;
  assign c2Out = (s1 & c1Lower) | (s1 & qn) | (c1Lower & qn);
endmodule

// File: rtl/montQCell.sv
// Least significant cell of a row. It carries the additional XOR gate that
// forms the quotient bit, and it broadcasts that bit to the rest of the row.
module montQCell (
  input  logic sIn,
  input  logic cIn,
  input  logic xyBit,
  input  logic nBit,
  output logic qOut,
  output logic c1Out,
  output logic s2Out,
  output logic c2Out
);
  logic s1;
  logic qn;

  // Quotient: parity of the running sum's low bit plus x_k*y0.
  assign qOut  = (sIn ^ cIn) ^ xyBit;
  assign s1    = sIn ^ cIn ^ xyBit;
  assign c1Out = (sIn & cIn) | (sIn & xyBit) | (cIn & xyBit);
  assign qn    = qOut & nBit;
  // No layer-one carry arrives from below bit 0.
  assign s2Out = s1 ^ qn;
  assign c2Out = s1 & qn;
endmodule

// File: rtl/montDatapath.sv
module montDatapath
  import montPkg::*;
#(
  parameter int OPW = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  montStrobes_t       strb,
  input  logic [OPW-1:0]     opX,
  input  logic [OPW-1:0]     opY,
  input  logic [OPW-1:0]     modN,
  output logic [OPW-1:0]     result
);
  localparam int W = OPW + GUARD_BITS;

  logic [W-1:0] yExt;
  logic [W-1:0] nExt;
  logic [W-1:0] rowS [OPW+1];
  logic [W-1:0] rowC [OPW+1];

  assign yExt    = {{GUARD_BITS{1'b0}}, opY};
  assign nExt    = {{GUARD_BITS{1'b0}}, modN};
  assign rowS[0] = '0;
  assign rowC[0] = '0;

  // One row per multiplier bit; the running sum stays in carry-save form.
  for (genvar k = 0; k < OPW; k++) begin : gRow
    logic [W-1:0] c1;
    logic [W-1:0] s2;
    logic [W-1:0] c2;
    logic         q;
    logic         unusedLsb;

    for (genvar j = 0; j < W; j++) begin : gCol
      if (j == 0) begin : gQ
        montQCell uQ (
          .sIn   (rowS[k][0]),
          .cIn   (rowC[k][0]),
          .xyBit (opX[k] & yExt[0]),
          .nBit  (nExt[0]),
          .qOut  (q),
          .c1Out (c1[0]),
          .s2Out (s2[0]),
          .c2Out (c2[0])
        );
      end else begin : gB
        montCell uB (
          .sIn     (rowS[k][j]),
          .cIn     (rowC[k][j]),
          .xyBit   (opX[k] & yExt[j]),
          .qBit    (q),
          .nBit    (nExt[j]),
          .c1Lower (c1[j-1]),
          .c1Out   (c1[j]),
          .s2Out   (s2[j]),
          .c2Out   (c2[j])
        );
      end
    end

    // Halving: the total is even, so bit 0 of the sum vector is always zero.
    // The top sum bit takes the carry out of the highest layer-one adder.
    assign unusedLsb  = s2[0];
    assign rowS[k+1]  = {c1[W-1], s2[W-1:1]};
    assign rowC[k+1]  = c2;
  end

  // Stage one: carry-save pair and the modulus that belongs to it.
  logic [W-1:0]   csS;
  logic [W-1:0]   csC;
  logic [OPW-1:0] modHeld;
  logic [OPW-1:0] resReg;

  // Parallel-prefix carry-lookahead resolution of the pair.
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] halfSum;
  logic [W-1:0] sumV;

  always_comb begin
    halfSum = csS ^ csC;
    gen     = csS & csC;
    prop    = halfSum;
    for (int d = 1; d < W; d = d * 2) begin
      gen  = gen | (prop & (gen << d));
      prop = prop & (prop << d);
    end
    sumV = halfSum ^ {gen[W-2:0], 1'b0};
  end

  // Final conditional subtraction: the sum is below 2N, so one pass suffices.
  logic [W-1:0]   modWide;
  logic [W-1:0]   redV;
  logic           atLeastN;
  logic [OPW-1:0] reduced;
  logic [2*GUARD_BITS-1:0] unusedHigh;

  assign modWide    = {{GUARD_BITS{1'b0}}, modHeld};
  assign atLeastN   = (sumV >= modWide);
  assign redV       = sumV - modWide;
  assign reduced    = atLeastN ? redV[OPW-1:0] : sumV[OPW-1:0];
  assign unusedHigh = {redV[W-1:OPW], sumV[W-1:OPW]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS     <= '0;
      csC     <= '0;
      modHeld <= '0;
      resReg  <= '0;
    end else begin
      if (strb.csLoad) begin
        csS     <= rowS[OPW];
        csC     <= rowC[OPW];
        modHeld <= modN;
      end
      if (strb.resLoad) begin
        resReg <= reduced;
      end
    end
  end

  assign result = resReg;
endmodule

// File: rtl/montControl.sv
module montControl
  import montPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output montStrobes_t strb,
  output logic         outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  assign strb.csLoad  = inValid;
  assign strb.resLoad = stage1Valid;
  assign outValid     = stage2Valid;
endmodule

// File: rtl/montMulTop.sv
module montMulTop
  import montPkg::*;
#(
  parameter int OPW = 9
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [OPW-1:0] opX,
  input  logic [OPW-1:0] opY,
  input  logic [OPW-1:0] modN,
  output logic           outValid,
  output logic [OPW-1:0] result
);
  montStrobes_t strb;

  montControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  montDatapath #(.OPW(OPW)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opX    (opX),
    .opY    (opY),
    .modN   (modN),
    .result (result)
  );
endmodule

// File: rtl/montMulChecker.sv
module montMulChecker #(
  parameter int OPW = 9
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [OPW-1:0] opX,
  input logic [OPW-1:0] opY,
  input logic [OPW-1:0] modN,
  input logic           outValid,
  input logic [OPW-1:0] result
);
  logic [1:0] sinceRst;
  logic       rstLowPrev = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  always @(posedge clk) begin
    // R4: reset held across two sampling edges leaves idle outputs.
    if (!rstN && rstLowPrev) begin
      assert_reset_idle_R4: assert (!outValid && result == '0)
        else $error("reset state violated");
    end
    rstLowPrev <= !rstN;
  end

  // R3: answer flag follows the request flag by exactly two edges.
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R2: every answer is below its own modulus.
  assert_below_mod_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && outValid) |-> (result < $past(modN, 2)));

  // R7: a zero operand gives a zero product.
  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && outValid && ($past(opX, 2) == '0 || $past(opY, 2) == '0))
      |-> (result == '0));

  // R5: without a fresh answer the output holds.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && !outValid) |-> $stable(result));
endmodule

bind montMulTop montMulChecker #(.OPW(OPW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opX      (opX),
  .opY      (opY),
  .modN     (modN),
  .outValid (outValid),
  .result   (result)
);

// File: tb/test_montMulTop.sv
`timescale 1ns/1ps
module test_montMulTop;
  localparam int OPW = 9;
  localparam int WATCHDOG_NS = 200000;

  logic           clk = 1'b0;
  logic           rstN;
  logic           inValid;
  logic [OPW-1:0] opX;
  logic [OPW-1:0] opY;
  logic [OPW-1:0] modN;
  logic           outValid;
  logic [OPW-1:0] result;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  montMulTop #(.OPW(OPW)) i_montMulTop (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opX      (opX),
    .opY      (opY),
    .modN     (modN),
    .outValid (outValid),
    .result   (result)
  );

  // Expected outcome queue: one entry per driven cycle.
  int    qValid [$];
  int    qValue [$];
  int    qMod   [$];
  string qTag   [$];
  int    lastExp = 0;

  // Reference: the unique Z in [0,N) with Z*2^n = X*Y (mod N).
  function automatic int montRef(int x, int y, int n);
    longint prod;
    prod = (longint'(x) * longint'(y)) % n;
    for (int z = 0; z < n; z++) begin
      if (((longint'(z) << OPW) % n) == prod) return z;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareDue();
    int    v;
    int    e;
    int    m;
    string t;
    if (qValid.size() < 2) return;
    v = qValid.pop_front();
    e = qValue.pop_front();
    m = qMod.pop_front();
    t = qTag.pop_front();
    check(int'(outValid) == v, "R3", "outValid timing", int'(outValid), v);
    if (v != 0) begin
      check(int'(result) == e, t, "product", int'(result), e);
      check(int'(result) < m, "R2", "result below modulus", int'(result), m);
      lastExp = e;
    end else begin
      check(int'(result) == lastExp, "R5", "hold while idle", int'(result), lastExp);
    end
  endtask

  task automatic cycleOp(bit v, int x, int y, int n, string tag);
    @(negedge clk);
    compareDue();
    inValid = v;
    opX     = OPW'(x);
    opY     = OPW'(y);
    modN    = OPW'(n);
    qValid.push_back(int'(v));
    qValue.push_back(v ? montRef(x, y, n) : 0);
    qMod.push_back(n);
    qTag.push_back(tag);
  endtask

  initial begin
    rstN    = 1'b0;
    inValid = 1'b0;
    opX     = '0;
    opY     = '0;
    modN    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R4", "outValid in reset", int'(outValid), 0);
    check(result == '0, "R4", "result in reset", int'(result), 0);
    rstN = 1'b1;

    // R7: zero operands, back to back
    cycleOp(1, 0, 5, 511, "R7");
    cycleOp(1, 7, 0, 511, "R7");
    cycleOp(1, 0, 0, 97, "R7");
    cycleOp(0, 3, 3, 7, "R5");

    // R8: extreme moduli
    cycleOp(1, 510, 510, 511, "R8");
    cycleOp(1, 0, 0, 1, "R8");
    cycleOp(1, 510, 1, 511, "R8");
    cycleOp(0, 0, 0, 0, "R5");

    // R6: random requests every cycle
    for (int i = 0; i < 200; i++) begin
      int n;
      n = int'($urandom % 256) * 2 + 1;
      cycleOp(1, int'($urandom % n), int'($urandom % n), n, "R6");
    end

    // R1 with idle gaps; R5 idle cycles carry junk operands
    for (int i = 0; i < 300; i++) begin
      int n;
      n = int'($urandom % 256) * 2 + 1;
      if ($urandom % 2 == 0)
        cycleOp(1, int'($urandom % n), int'($urandom % n), n, "R1");
      else
        cycleOp(0, int'($urandom % 512), int'($urandom % 512), int'($urandom % 512), "R5");
    end

    // drain the pipeline
    for (int i = 0; i < 3; i++) cycleOp(0, 0, 0, 1, "R5");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule